// File: doc/BRIEF.md
# Linked-List DMA Channel Sequencer

This block drives a single DMA channel through a chain of transfer nodes. Software programs the first node straight into a small register window (next pointer, byte count, source, destination, configuration), then sets the configuration enable bit. The channel copies the node word by word over a simple memory port. Each cycle in which the port grants, it reads one word at the source address and writes the same word at the destination address. When a node's count reaches zero and its next pointer has the chain flag set, the channel fetches the next 32-byte node record from memory and continues. Otherwise the chain is complete.

Node records use the same word layout as the register window, so a node can be written to memory or to the registers in the same form. A list whose last node points back to its first runs forever; the only way out is to clear the enable bit. Clearing the enable bit freezes the channel exactly where it stands, and setting it again resumes from that point. While frozen, software may rewrite the working node and then resume. This gives both a terminate-and-restart path and a way to leave a circular list. The direction, request-line, width and burst fields of the configuration are stored and can be read back, but they do not affect the copy.

Top module: `lldma_channel`

## Requirements
- R1: After reset the channel is idle: busy, memReq, nodeDone and chainDone are low, and every window register reads 0.
- R2: Window offsets are: next pointer 0x00, current count 0x04 (read-only, count in bits 15:0), count 0x10, source 0x14, destination 0x18, configuration 0x1C. A count is stored as the written value AND 0x1FFC. Other registers keep all 32 bits. Unmapped offsets read 0.
- R3: Writing the configuration with bit 0 set while idle starts the channel, and busy is high from the next cycle. A configuration write with bit 0 clear while idle only stores the value.
- R4: Each granted beat (memReq and memWrEn high with memGnt) copies the word read at memRdAddr to memWrAddr and lowers the count by 4. The source advances by 4 only when configuration bit 31 is set, and the destination only when bit 30 is set.
- R5: A request that is not granted moves nothing and holds the address presented.
- R6: When a node's count is zero, bit 1 of its next pointer is set and the pointer's bits 31:5 are non-zero, the channel reads the 8 words of the record at that address with bits 4:0 cleared, in order. Word 0 is the next pointer, words 1 to 3 are ignored, word 4 is the count (masked as in R2), word 5 the source, word 6 the destination and word 7 the configuration. All working registers are replaced together after word 7.
- R7: When a node whose configuration bit 1 is set ends, nodeDone pulses high for one cycle.
- R8: When a node ends with no chaining (bit 1 of the next pointer clear, or pointer bits 31:5 zero), chainDone pulses for one cycle and busy falls in the same cycle.
- R9: A list whose last node points back to an earlier node keeps running, with no chainDone, while the enable bit stays set.
- R10: Clearing configuration bit 0 while busy stops all memory requests from the next cycle. The channel stays busy and its state is held. Setting bit 0 again resumes from the same point.
- R11: While busy and enabled, writes to the next pointer, count, source and destination are ignored. While busy, a configuration write changes only bit 0. While busy and paused, those four registers accept writes, an interrupted record fetch is abandoned, and resuming runs the rewritten node.
- R12: A pause write in the same cycle as a granted beat lets that beat complete, so the count has dropped by exactly that beat.
- R13: A node with count 0 ends without any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Window register write strobe |
| regAddr | input | 6 | Byte offset of the write within the window |
| regWrData | input | 32 | Write data |
| regRdAddr | input | 6 | Byte offset of the combinational read |
| regRdData | output | 32 | Read data |
| memReq | output | 1 | Memory access request |
| memWrEn | output | 1 | High for a copy beat (read and write), low for a record fetch (read only) |
| memRdAddr | output | 32 | Read address (source or record word) |
| memRdData | input | 32 | Read data, valid in the cycle of the request |
| memWrAddr | output | 32 | Write address (destination) |
| memWrData | output | 32 | Write data |
| memGnt | input | 1 | Grant; the access happens at the clock edge while memReq and memGnt are high |
| busy | output | 1 | Channel holds an unfinished chain |
| nodeDone | output | 1 | One-cycle pulse at the end of a node that asked for it |
| chainDone | output | 1 | One-cycle pulse at the end of the chain |

## Verification
Two events can coincide in one cycle: a software pause write and a granted copy beat. The bench places a configuration write with bit 0 clear on the second beat after start, with the grant held high. It then expects the count to show exactly two beats taken, the third destination word to stay untouched, and the count to stay fixed while paused. A second coincidence is a node end that raises nodeDone and chainDone together. A zero-count node with the interrupt bit set provokes it, and the bench requires both pulses with no memory write.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  localparam int WORD_BYTES = 4;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int ALIGN_B    = $clog2(DESC_WORDS * WORD_BYTES);

  // window offsets mirror the record word positions (word index * 4)
  localparam logic [5:0] OFS_NEXT = 6'h00;
  localparam logic [5:0] OFS_CUR  = 6'h04;
  localparam logic [5:0] OFS_CNT  = 6'h10;
  localparam logic [5:0] OFS_SRC  = 6'h14;
  localparam logic [5:0] OFS_DST  = 6'h18;
  localparam logic [5:0] OFS_CFG  = 6'h1C;

  localparam int W_NEXT = 0;
  localparam int W_CNT  = 4;
  localparam int W_SRC  = 5;
  localparam int W_DST  = 6;

  localparam int CFG_EN    = 0;
  localparam int CFG_IRQ   = 1;
  localparam int CFG_DINC  = 30;
  localparam int CFG_SINC  = 31;
  localparam int CHAIN_BIT = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_FETCH} chState_t;

  typedef struct packed {
    logic             beat;
    logic             fetchSel;
    logic             fetchStart;
    logic             fetchWord;
    logic [IDX_W-1:0] fetchIdx;
    logic             commit;
  } dpStrobe_t;
endpackage

// File: rtl/lldma_ctrl.sv
module lldma_ctrl
  import lldma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       nodeRewrite,
  input  logic       cfgEn,
  input  logic       nodeIrq,
  input  logic       countZero,
  input  logic       chainNext,
  input  logic       memGnt,
  output dpStrobe_t  strobe,
  output logic       memReq,
  output logic       memWrEn,
  output logic       busy,
  output logic       nodeDone,
  output logic       chainDone
);
  chState_t         state, stateNext;
  logic [IDX_W-1:0] idx, idxNext;
  logic             nodeDoneD, chainDoneD;

  always_comb begin
    stateNext       = state;
    idxNext         = idx;
    strobe          = '0;
    strobe.fetchIdx = idx;
    memReq          = 1'b0;
    memWrEn         = 1'b0;
    nodeDoneD       = 1'b0;
    chainDoneD      = 1'b0;
    case (state)
      ST_IDLE: if (startReq) stateNext = ST_XFER;
      ST_XFER: begin
        if (cfgEn) begin
          if (countZero) begin
            nodeDoneD = nodeIrq;
            if (chainNext) begin
              stateNext         = ST_FETCH;
              idxNext           = '0;
              strobe.fetchStart = 1'b1;
            end else begin
              chainDoneD = 1'b1;
              stateNext  = ST_IDLE;
            end
          end else begin
            memReq      = 1'b1;
            memWrEn     = 1'b1;
            strobe.beat = memGnt;
          end
        end
      end
      ST_FETCH: begin
        strobe.fetchSel = 1'b1;
        if (nodeRewrite) begin
          stateNext = ST_XFER;
        end else if (cfgEn) begin
          memReq = 1'b1;
          if (memGnt) begin
            strobe.fetchWord = 1'b1;
            if (idx == IDX_W'(DESC_WORDS - 1)) begin
              strobe.commit = 1'b1;
              stateNext     = ST_XFER;
            end else begin
              idxNext = idx + 1'b1;
            end
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idx       <= '0;
      nodeDone  <= 1'b0;
      chainDone <= 1'b0;
    end else begin
      state     <= stateNext;
      idx       <= idxNext;
      nodeDone  <= nodeDoneD;
      chainDone <= chainDoneD;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/lldma_dpath.sv
module lldma_dpath
  import lldma_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 13,
  parameter int WIN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             busy,
  input  logic             regWrEn,
  input  logic [WIN_W-1:0] regAddr,
  input  logic [DW-1:0]    regWrData,
  input  logic [WIN_W-1:0] regRdAddr,
  output logic [DW-1:0]    regRdData,
  input  logic [DW-1:0]    memRdData,
  output logic [DW-1:0]    memRdAddr,
  output logic [DW-1:0]    memWrAddr,
  output logic [DW-1:0]    memWrData,
  output logic             cfgEn,
  output logic             nodeIrq,
  output logic             countZero,
  output logic             chainNext,
  output logic [15:0]      curCount
);
  localparam logic [DW-1:0] CNT_MASK  = DW'((64'd1 << CNT_W) - 64'd1) & ~DW'(WORD_BYTES - 1);
  localparam logic [DW-1:0] WORD_STEP = DW'(WORD_BYTES);

  logic [DW-1:0] nextPtr, cnt, src, dst, cfg, nodeBase;
  logic [DW-1:0] shNext, shCnt, shSrc, shDst;
  logic          wrOk, cfgWr;

  assign wrOk  = regWrEn && (!busy || !cfg[CFG_EN]);
  assign cfgWr = regWrEn && (regAddr == OFS_CFG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPtr  <= '0;
      cnt      <= '0;
      src      <= '0;
      dst      <= '0;
      cfg      <= '0;
      nodeBase <= '0;
      shNext   <= '0;
      shCnt    <= '0;
      shSrc    <= '0;
      shDst    <= '0;
    end else begin
      if (wrOk) begin
        case (regAddr)
          OFS_NEXT: nextPtr <= regWrData;
          OFS_CNT:  cnt     <= regWrData & CNT_MASK;
          OFS_SRC:  src     <= regWrData;
          OFS_DST:  dst     <= regWrData;
          default:  ;
        endcase
      end
      if (cfgWr) begin
        if (!busy) cfg <= regWrData;
        else       cfg[CFG_EN] <= regWrData[CFG_EN];
      end
      if (strobe.beat) begin
        cnt <= cnt - WORD_STEP;
        if (cfg[CFG_SINC]) src <= src + WORD_STEP;
        if (cfg[CFG_DINC]) dst <= dst + WORD_STEP;
      end
      if (strobe.fetchStart)
        nodeBase <= {nextPtr[DW-1:ALIGN_B], ALIGN_B'(0)};
      if (strobe.fetchWord) begin
        case (strobe.fetchIdx)
          IDX_W'(W_NEXT): shNext <= memRdData;
          IDX_W'(W_CNT):  shCnt  <= memRdData & CNT_MASK;
          IDX_W'(W_SRC):  shSrc  <= memRdData;
          IDX_W'(W_DST):  shDst  <= memRdData;
          default:        ;
        endcase
      end
      if (strobe.commit) begin
        nextPtr <= shNext;
        cnt     <= shCnt;
        src     <= shSrc;
        dst     <= shDst;
        cfg     <= cfgWr ? {memRdData[DW-1:1], regWrData[CFG_EN]} : memRdData;
      end
    end
  end

  assign memRdAddr = strobe.fetchSel ? (nodeBase + DW'({strobe.fetchIdx, 2'b00})) : src;
  assign memWrAddr = dst;
  assign memWrData = memRdData;
  assign cfgEn     = cfg[CFG_EN];
  assign nodeIrq   = cfg[CFG_IRQ];
  assign countZero = (cnt == '0);
  assign chainNext = nextPtr[CHAIN_BIT] && (|nextPtr[DW-1:ALIGN_B]);
  assign curCount  = cnt[15:0];

  always_comb begin
    case (regRdAddr)
      OFS_NEXT: regRdData = nextPtr;
      OFS_CUR:  regRdData = DW'(cnt[15:0]);
      OFS_CNT:  regRdData = cnt;
      OFS_SRC:  regRdData = src;
      OFS_DST:  regRdData = dst;
      OFS_CFG:  regRdData = cfg;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
  import lldma_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 13,
  parameter int WIN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [WIN_W-1:0] regAddr,
  input  logic [DW-1:0]    regWrData,
  input  logic [WIN_W-1:0] regRdAddr,
  output logic [DW-1:0]    regRdData,
  output logic             memReq,
  output logic             memWrEn,
  output logic [DW-1:0]    memRdAddr,
  input  logic [DW-1:0]    memRdData,
  output logic [DW-1:0]    memWrAddr,
  output logic [DW-1:0]    memWrData,
  input  logic             memGnt,
  output logic             busy,
  output logic             nodeDone,
  output logic             chainDone
);
  dpStrobe_t   strobe;
  logic        cfgEn, nodeIrq, countZero, chainNext;
  logic        startReq, nodeRewrite, nodeRegHit;
  logic [15:0] curCount;

  assign nodeRegHit  = (regAddr == OFS_NEXT) || (regAddr == OFS_CNT) ||
                       (regAddr == OFS_SRC)  || (regAddr == OFS_DST);
  assign startReq    = regWrEn && (regAddr == OFS_CFG) && regWrData[CFG_EN] && !busy;
  assign nodeRewrite = regWrEn && busy && !cfgEn && nodeRegHit;

  lldma_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .nodeRewrite(nodeRewrite),
    .cfgEn      (cfgEn),
    .nodeIrq    (nodeIrq),
    .countZero  (countZero),
    .chainNext  (chainNext),
    .memGnt     (memGnt),
    .strobe     (strobe),
    .memReq     (memReq),
    .memWrEn    (memWrEn),
    .busy       (busy),
    .nodeDone   (nodeDone),
    .chainDone  (chainDone)
  );

  lldma_dpath #(.DW(DW), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busy      (busy),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdAddr (regRdAddr),
    .regRdData (regRdData),
    .memRdData (memRdData),
    .memRdAddr (memRdAddr),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .cfgEn     (cfgEn),
    .nodeIrq   (nodeIrq),
    .countZero (countZero),
    .chainNext (chainNext),
    .curCount  (curCount)
  );
endmodule

// File: rtl/lldma_checker.sv
module lldma_checker #(
  parameter int DW    = 32,
  parameter int WIN_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [WIN_W-1:0] regAddr,
  input logic             cfgWrBit,
  input logic             memReq,
  input logic             memWrEn,
  input logic             memGnt,
  input logic [DW-1:0]    memRdAddr,
  input logic             busy,
  input logic             chainDone,
  input logic [15:0]      curCount
);
  logic cfgHit;
  assign cfgHit = regWrEn && (regAddr == WIN_W'(6'h1C));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (cfgHit && cfgWrBit && !busy) |=> busy);

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrEn && memGnt) |=> (curCount == $past(curCount) - 16'd4));

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> $stable(memRdAddr));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    chainDone |-> !busy);

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    chainDone |=> !chainDone);

  a_r10_pause_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cfgHit && !cfgWrBit && busy) |=> !memReq);
endmodule

bind lldma_channel lldma_checker #(.DW(DW), .WIN_W(WIN_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .cfgWrBit (regWrData[0]),
  .memReq   (memReq),
  .memWrEn  (memWrEn),
  .memGnt   (memGnt),
  .memRdAddr(memRdAddr),
  .busy     (busy),
  .chainDone(chainDone),
  .curCount (curCount)
);

// File: tb/lldma_channel_test.sv
module lldma_channel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [5:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        memReq, memWrEn, memGnt;
  logic [31:0] memRdAddr, memRdData, memWrAddr, memWrData;
  logic        busy, nodeDone, chainDone;

  logic [31:0] mem [0:1023];
  logic        gntStall = 1'b0;
  logic        gntToggle = 1'b0;
  int          checks = 0, failures = 0, cycles = 0;
  int          nodeCnt = 0, chainCnt = 0, wrCnt = 0;

  always #5 clk = ~clk;

  lldma_channel uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData), .memReq(memReq), .memWrEn(memWrEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memGnt(memGnt), .busy(busy), .nodeDone(nodeDone), .chainDone(chainDone)
  );

  assign memRdData = mem[memRdAddr[11:2]];
  assign memGnt    = gntStall ? gntToggle : 1'b1;

  always @(posedge clk) begin
    gntToggle <= ~gntToggle;
    cycles    <= cycles + 1;
    if (memReq && memGnt && memWrEn) mem[memWrAddr[11:2]] <= memWrData;
  end

  always @(negedge clk) begin
    if (nodeDone) nodeCnt++;
    if (chainDone) chainCnt++;
    if (memReq && memGnt && memWrEn) wrCnt++;
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
    report();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [5:0] a, output logic [31:0] d);
    regRdAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic rdChk(input logic [5:0] a, input logic [31:0] exp, input string req, input string what);
    logic [31:0] v;
    rdReg(a, v);
    chk(v === exp, req, what, v, exp);
  endtask

  task automatic loadNode(input logic [31:0] nxt, cnt, src, dst);
    wrReg(6'h00, nxt);
    wrReg(6'h10, cnt);
    wrReg(6'h14, src);
    wrReg(6'h18, dst);
  endtask

  task automatic clearCounters();
    nodeCnt = 0; chainCnt = 0; wrCnt = 0;
  endtask

  task automatic waitIdle(input int limit, input string req);
    int n = 0;
    while (busy && n < limit) begin
      @(negedge clk);
      n++;
    end
    #1;
    chk(!busy, req, "channel returns idle", 32'(busy), 32'd0);
  endtask

  task automatic putRecord(input int base, input logic [31:0] nxt, cnt, src, dst, cfg);
    mem[base/4 + 0] = nxt;
    mem[base/4 + 1] = 32'hDEAD_0001;
    mem[base/4 + 2] = 32'hDEAD_0002;
    mem[base/4 + 3] = 32'hDEAD_0003;
    mem[base/4 + 4] = cnt;
    mem[base/4 + 5] = src;
    mem[base/4 + 6] = dst;
    mem[base/4 + 7] = cfg;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
    chk(memReq == 1'b0, "R1", "memReq after reset", 32'(memReq), 0);
    chk(!nodeDone && !chainDone, "R1", "events after reset", 32'({nodeDone, chainDone}), 0);
    rdChk(6'h1C, 32'h0, "R1", "config after reset");
    rdChk(6'h04, 32'h0, "R1", "current count after reset");
  endtask

  task automatic testRegs();
    wrReg(6'h10, 32'hFFFF_E013);
    rdChk(6'h10, 32'h0000_0010, "R2", "count masked to 0x1FFC");
    rdChk(6'h04, 32'h0000_0010, "R2", "current count low half");
    wrReg(6'h14, 32'h1234_5678);
    rdChk(6'h14, 32'h1234_5678, "R2", "source register");
    rdChk(6'h28, 32'h0, "R2", "unmapped offset");
    wrReg(6'h1C, 32'hC033_30A4);
    rdChk(6'h1C, 32'hC033_30A4, "R2", "config fields stored");
    chk(!busy, "R3", "config without enable does not start", 32'(busy), 0);
  endtask

  task automatic testCopy();
    for (int i = 0; i < 4; i++) mem[64 + i] = 32'hA000_0000 + i;
    clearCounters();
    loadNode(32'h0, 32'd16, 32'h100, 32'h200);
    wrReg(6'h1C, 32'hC000_0001);
    chk(busy, "R3", "busy after start", 32'(busy), 1);
    waitIdle(100, "R8");
    for (int i = 0; i < 4; i++)
      chk(mem[128 + i] == 32'hA000_0000 + i, "R4", "copied word", mem[128 + i], 32'hA000_0000 + i);
    chk(chainCnt == 1, "R8", "one chain pulse", chainCnt, 1);
    chk(nodeCnt == 0, "R7", "no node pulse without bit 1", nodeCnt, 0);
    rdChk(6'h04, 32'h0, "R4", "count at end");
    rdChk(6'h14, 32'h110, "R4", "source advanced");
    rdChk(6'h18, 32'h210, "R4", "destination advanced");
  endtask

  task automatic testFixed();
    mem[80] = 32'h5555_0001;
    loadNode(32'h0, 32'd12, 32'h140, 32'h280);
    wrReg(6'h1C, 32'h4000_0001);
    waitIdle(100, "R4");
    for (int i = 0; i < 3; i++)
      chk(mem[160 + i] == 32'h5555_0001, "R4", "fixed source replicated", mem[160 + i], 32'h5555_0001);
    rdChk(6'h14, 32'h140, "R4", "fixed source held");
    for (int i = 0; i < 3; i++) mem[96 + i] = 32'hB000_0000 + i;
    mem[177] = 32'h0;
    loadNode(32'h0, 32'd12, 32'h180, 32'h2C0);
    wrReg(6'h1C, 32'h8000_0001);
    waitIdle(100, "R4");
    chk(mem[176] == 32'hB000_0002, "R4", "fixed destination holds last", mem[176], 32'hB000_0002);
    chk(mem[177] == 32'h0, "R4", "next destination untouched", mem[177], 32'h0);
  endtask

  task automatic testStall();
    int start;
    for (int i = 0; i < 8; i++) mem[64 + i] = 32'hC100_0000 + i;
    gntStall = 1'b1;
    loadNode(32'h0, 32'd32, 32'h100, 32'h300);
    wrReg(6'h1C, 32'hC000_0001);
    start = cycles;
    wrReg(6'h14, 32'h3F0);
    waitIdle(200, "R5");
    gntStall = 1'b0;
    chk((cycles - start) >= 16, "R5", "stalled run takes two cycles per word", cycles - start, 16);
    for (int i = 0; i < 8; i++)
      chk(mem[192 + i] == 32'hC100_0000 + i, "R5", "word under stalls", mem[192 + i], 32'hC100_0000 + i);
    rdChk(6'h14, 32'h120, "R11", "source write while running ignored");
  endtask

  task automatic testChain();
    for (int i = 0; i < 6; i++) mem[64 + i] = 32'hD200_0000 + i;
    for (int i = 0; i < 8; i++) mem[208 + i] = 32'h0;
    putRecord(32'h400, 32'h422, 32'hFFFF_0008, 32'h108, 32'h348, 32'hC000_0003);
    putRecord(32'h420, 32'h0, 32'h4, 32'h110, 32'h350, 32'hC000_0001);
    clearCounters();
    loadNode(32'h402, 32'd8, 32'h100, 32'h340);
    wrReg(6'h1C, 32'hC000_0001);
    waitIdle(300, "R6");
    for (int i = 0; i < 5; i++)
      chk(mem[208 + i] == 32'hD200_0000 + i, "R6", "chained copy", mem[208 + i], 32'hD200_0000 + i);
    chk(mem[213] == 32'h0, "R6", "record count masked", mem[213], 32'h0);
    chk(nodeCnt == 1, "R7", "node pulse from middle node", nodeCnt, 1);
    chk(chainCnt == 1, "R8", "chain pulse after last node", chainCnt, 1);
    rdChk(6'h00, 32'h0, "R6", "last node pointer loaded");
    rdChk(6'h1C, 32'hC000_0001, "R6", "last node config loaded");
  endtask

  task automatic testCircular();
    int w;
    putRecord(32'h500, 32'h522, 32'h4, 32'h100, 32'h380, 32'hC000_0003);
    putRecord(32'h520, 32'h502, 32'h4, 32'h104, 32'h384, 32'hC000_0003);
    clearCounters();
    loadNode(32'h502, 32'd4, 32'h100, 32'h380);
    wrReg(6'h1C, 32'hC000_0003);
    repeat (200) @(negedge clk);
    chk(nodeCnt >= 4, "R9", "circular list keeps pulsing", nodeCnt, 4);
    chk(chainCnt == 0 && busy, "R9", "circular list never ends", chainCnt, 0);
    wrReg(6'h1C, 32'h0);
    repeat (2) @(negedge clk);
    w = wrCnt;
    repeat (20) @(negedge clk);
    chk(wrCnt == w && !memReq, "R10", "no access while paused", wrCnt, w);
    chk(busy, "R10", "busy held while paused", 32'(busy), 1);
    mem[232] = 32'h0;
    loadNode(32'h0, 32'd4, 32'h100, 32'h3A0);
    clearCounters();
    wrReg(6'h1C, 32'h1);
    waitIdle(100, "R11");
    chk(mem[232] == mem[64], "R11", "rewritten node runs after resume", mem[232], mem[64]);
    chk(chainCnt == 1, "R11", "restart ends chain", chainCnt, 1);
    rdChk(6'h1C, 32'hC000_0003, "R11", "busy config write kept upper bits");
  endtask

  task automatic testZero();
    clearCounters();
    loadNode(32'h700, 32'd0, 32'h100, 32'h3C0);
    wrReg(6'h1C, 32'hC000_0003);
    waitIdle(20, "R13");
    chk(wrCnt == 0, "R13", "zero count makes no access", wrCnt, 0);
    chk(nodeCnt == 1 && chainCnt == 1, "R8", "unchained pointer ends chain with node pulse",
        32'({nodeCnt[15:0], chainCnt[15:0]}), 32'h0001_0001);
  endtask

  task automatic testCoincide();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) mem[256 + i] = 32'h0;
    loadNode(32'h0, 32'd64, 32'h100, 32'h400);
    wrReg(6'h1C, 32'hC000_0001);
    wrReg(6'h1C, 32'hC000_0000);
    rdReg(6'h04, v);
    chk(v == 32'd56, "R12", "beat under pause write completes", v, 32'd56);
    chk(mem[258] == 32'h0, "R12", "third word not written", mem[258], 32'h0);
    repeat (5) @(negedge clk);
    rdReg(6'h04, v);
    chk(v == 32'd56, "R10", "count frozen while paused", v, 32'd56);
    wrReg(6'h1C, 32'h1);
    waitIdle(100, "R10");
    chk(mem[271] == mem[79], "R10", "resumed node finishes", mem[271], mem[79]);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testCopy();
    testFixed();
    testStall();
    testChain();
    testCircular();
    testZero();
    testCoincide();
    report();
  end
endmodule